// File: doc/BRIEF.md
# Radio Frame Timer with Symbol-Length Table

This block generates the sample-level timing of a radio frame. A sample counter runs from zero up to a programmed frame terminal count, and in parallel a symbol walker steps through a table of per-symbol lengths. When the valid part of the table is shorter than the frame, the walker loops back to entry 0. The block gives a frame-start strobe, a symbol-start strobe, the running sample count, the current table index and a wrapping frame number.

Software writes a shadow set of registers through a single-cycle write port. The shadow set holds the symbol table, the index of the last valid entry and the frame terminal count. The shadow set is copied into the active set on the last sample of a frame, so the contents of a frame never change while that frame runs. This lets software stretch or shrink a single frame by one sample, for example to nudge timing. At every frame end the block checks that the symbols close exactly on the last sample of the frame. If they do not, a sticky error stops the symbol strobes until software re-arms the block. Software can also stop the timer at a frame end and restart it from a halted state.

Top module: `rft_frame_timer`

## Requirements
- R1: After a synchronous active-low reset: `halted`=1, `frame_start`=0, `sym_start`=0, `err_flag`=0, `commit_pending`=0, `frame_num`=0, `sample_cnt`=0.
- R2: While running with active frame terminal count T, `sample_cnt` counts 0..T and `frame_start` is high exactly when `sample_cnt` is 0. Successive frame starts are therefore T+1 cycles apart.
- R3: A table entry is written at address `{1'b0, index}` with `wr_data[15:0]` as the symbol terminal count L. That symbol lasts L+1 samples. `sym_start` marks its first sample, and `sym_idx` shows its table index.
- R4: The last-valid-index register is at address 0x100, in `wr_data[7:0]`. After that entry the walker returns to entry 0, and every frame restarts at entry 0, even when the frame ends partway through a pass over the table. A table of 140 valid entries is supported.
- R5: The frame terminal count is at address 0x101, in `wr_data[23:0]`. Writes to any shadow register change nothing in the current frame. They apply from the next `frame_start`.
- R6: Frame lengths of the nominal value, one sample more and one sample less can be chosen independently for consecutive frames, each with a consistent table.
- R7: `commit_pending` rises after any shadow write (table, last index, frame count) and falls when the shadow set is copied into the active set.
- R8: If at the last sample of a frame the current symbol has not reached its own last sample, `err_flag` is set and stays set. While it is set, `sym_start` stays low, and frame strobes continue at the active frame length.
- R9: A write to address 0x102 re-arms the block. `err_flag` clears at the next frame boundary, and symbol strobes resume from entry 0 with that new frame.
- R10: Dropping `enable` lets the current frame finish, and `halted` rises the cycle after its last sample. Raising `enable` while halted loads the shadow set, and `frame_start` follows on the next cycle.
- R11: `frame_num` is 0 in the first frame after a start from halted, increments at each frame boundary, and wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; sampled at frame boundaries and while halted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Write address: bit 8 clear selects a table entry, set selects a control register |
| wr_data | input | 24 | Write data |
| frame_start | output | 1 | High on sample 0 of each frame |
| sym_start | output | 1 | High on the first sample of each symbol |
| sample_cnt | output | 24 | Sample index within the frame |
| sym_idx | output | 8 | Table index of the current symbol |
| frame_num | output | 12 | Frame number, wrapping at 4096 |
| err_flag | output | 1 | Sticky symbol/frame length mismatch |
| halted | output | 1 | Timer stopped |
| commit_pending | output | 1 | Shadow written but not yet loaded |

## Verification
The hardest state to reach is a boundary that carries two events at once: a detected mismatch, followed in a later frame by the re-arm landing on the same edge that loads the corrected terminal count. To get there, the stimulus first commits a frame count one sample longer than the table sum. It then watches one frame in which no symbol strobes appear. Finally it writes the corrected count and the re-arm mid-frame and checks that the error flag still holds until the boundary. The frame-number wrap needs 4096 frames, so the stimulus halts the timer and shrinks the frame to two samples to reach the wrap quickly.

// File: rtl/rft_pkg.sv
// Shared constants of the radio frame timer.
// Assumes control registers are decoded from the two low address bits when
// the table-select address bit is set.
package rft_pkg;
    localparam logic [1:0] CTL_LAST_IDX = 2'd0;  // last valid table index
    localparam logic [1:0] CTL_FRAME_TC = 2'd1;  // frame terminal count
    localparam logic [1:0] CTL_REARM    = 2'd2;  // clear error at next boundary
endpackage

// File: rtl/rft_cfg.sv
// Shadow and active configuration store.
// Software writes land in the shadow set; a commit pulse copies the whole
// shadow set into the active set in one cycle. Assumes FRM_W >= SYM_W and
// FRM_W >= LUT_AW so every field fits in the write data.
module rft_cfg
    import rft_pkg::*;
#(
    parameter int LUT_AW = 8,
    parameter int SYM_W = 16,
    parameter int FRM_W = 24,
    parameter logic [FRM_W-1:0] DEF_FTC = 24'd3071999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LUT_AW:0]   wr_addr,
    input  logic [FRM_W-1:0]  wr_data,
    input  logic              commit,
    input  logic [LUT_AW-1:0] rd_idx,
    output logic [SYM_W-1:0]  act_len,
    output logic [LUT_AW-1:0] act_last,
    output logic [FRM_W-1:0]  act_ftc,
    output logic              arm_req,
    output logic              pending
);
    localparam int DEPTH = 1 << LUT_AW;

    logic [SYM_W-1:0]  shd_lut [DEPTH];
    logic [SYM_W-1:0]  act_lut [DEPTH];
    logic [LUT_AW-1:0] shd_last;
    logic [FRM_W-1:0]  shd_ftc;
    logic              wr_tab, wr_ctl, shadow_wr;

    always_comb begin
        wr_tab    = wr_en && !wr_addr[LUT_AW];
        wr_ctl    = wr_en && wr_addr[LUT_AW];
        shadow_wr = wr_tab || (wr_ctl && (wr_addr[1:0] == CTL_LAST_IDX ||
                                          wr_addr[1:0] == CTL_FRAME_TC));
    end

    // Shadow table write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) shd_lut[i] <= '0;
        end else if (wr_tab) begin
            shd_lut[wr_addr[LUT_AW-1:0]] <= wr_data[SYM_W-1:0];
        end
    end

    // Active table load at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) act_lut[i] <= '0;
        end else if (commit) begin
            act_lut <= shd_lut;
        end
    end

    // Shadow and active control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_last <= '0;
            shd_ftc  <= DEF_FTC;
            act_last <= '0;
            act_ftc  <= DEF_FTC;
        end else begin
            if (wr_ctl && wr_addr[1:0] == CTL_LAST_IDX) shd_last <= wr_data[LUT_AW-1:0];
            if (wr_ctl && wr_addr[1:0] == CTL_FRAME_TC) shd_ftc <= wr_data;
            if (commit) begin
                act_last <= shd_last;
                act_ftc  <= shd_ftc;
            end
        end
    end

    // Re-arm request and commit-pending status; a same-cycle write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_req <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (wr_ctl && wr_addr[1:0] == CTL_REARM) arm_req <= 1'b1;
            else if (commit) arm_req <= 1'b0;
            if (shadow_wr) pending <= 1'b1;
            else if (commit) pending <= 1'b0;
        end
    end

    assign act_len = act_lut[rd_idx];

    assert_pending_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_wr |=> pending);
    assert_pending_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !shadow_wr |=> !pending);
    assert_commit_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> act_ftc == $past(shd_ftc));
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_ftc) && $stable(act_last));
endmodule

// File: rtl/rft_frame_ctr.sv
// Frame sample counter and run/halt control.
// Counts samples 0..act_ftc, raises the commit pulse on the last sample of a
// frame (or while halted with enable high) and keeps the frame number.
module rft_frame_ctr #(
    parameter int FRM_W = 24,
    parameter int FNUM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [FRM_W-1:0]  act_ftc,
    output logic              running,
    output logic [FRM_W-1:0]  smp,
    output logic [FNUM_W-1:0] fnum,
    output logic              frame_last,
    output logic              commit,
    output logic              frame_start
);
    always_comb begin
        frame_last  = running && (smp == act_ftc);
        commit      = enable && (frame_last || !running);
        frame_start = running && (smp == '0);
    end

    // Sample counter, run state and frame number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            smp     <= '0;
            fnum    <= '0;
        end else if (!running) begin
            running <= enable;
            smp     <= '0;
            fnum    <= '0;
        end else if (frame_last) begin
            running <= enable;
            smp     <= '0;
            if (enable) fnum <= fnum + 1'b1;
        end else begin
            smp <= smp + 1'b1;
        end
    end

    assert_sample_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running && !frame_last |=> smp == $past(smp) + 1'b1);
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last && enable |=> frame_start);
    assert_halt_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last && !enable |=> !running);
    assert_fnum_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last && enable |=> fnum == $past(fnum) + 1'b1);
endmodule

// File: rtl/rft_sym_walk.sv
// Symbol walker and frame consistency check.
// Steps through the active table, wrapping after the last valid entry, and
// restarts at entry 0 every frame. At the frame's last sample it checks that
// the current symbol also ends there; on a miss it sets a sticky error that
// freezes the walker until a re-arm arrives with a commit.
module rft_sym_walk #(
    parameter int LUT_AW = 8,
    parameter int SYM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              chk,
    input  logic              commit,
    input  logic              arm,
    input  logic [SYM_W-1:0]  len_tc,
    input  logic [LUT_AW-1:0] last,
    output logic [LUT_AW-1:0] ptr,
    output logic              sym_start,
    output logic              err
);
    logic [SYM_W-1:0] cnt;

    assign sym_start = run && !err && (cnt == '0);

    // Per-symbol sample count and table pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ptr <= '0;
        end else if (!run || chk) begin
            cnt <= '0;
            ptr <= '0;
        end else if (!err) begin
            if (cnt == len_tc) begin
                cnt <= '0;
                ptr <= (ptr == last) ? '0 : ptr + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Sticky mismatch flag, cleared only by a re-arm taken at a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (chk) begin
            if (err) begin
                if (commit && arm) err <= 1'b0;
            end else if (cnt != len_tc) begin
                err <= 1'b1;
            end
        end else if (commit && arm) begin
            err <= 1'b0;
        end
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err && !commit |=> err);
    assert_walk_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err && run && !chk |=> $stable(ptr) && $stable(cnt));
    assert_frame_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk |=> ptr == '0);
endmodule

// File: rtl/rft_frame_timer.sv
// Radio frame timer top: wires the configuration store, the frame counter
// and the symbol walker together. Assumes a single-cycle write port with no
// read-back; all timing outputs change only on clock edges.
module rft_frame_timer #(
    parameter int LUT_AW = 8,
    parameter int SYM_W = 16,
    parameter int FRM_W = 24,
    parameter int FNUM_W = 12,
    parameter logic [FRM_W-1:0] DEF_FTC = 24'd3071999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [LUT_AW:0]   wr_addr,
    input  logic [FRM_W-1:0]  wr_data,
    output logic              frame_start,
    output logic              sym_start,
    output logic [FRM_W-1:0]  sample_cnt,
    output logic [LUT_AW-1:0] sym_idx,
    output logic [FNUM_W-1:0] frame_num,
    output logic              err_flag,
    output logic              halted,
    output logic              commit_pending
);
    logic              running, frame_last, commit, arm_req;
    logic [SYM_W-1:0]  act_len;
    logic [LUT_AW-1:0] act_last, ptr;
    logic [FRM_W-1:0]  act_ftc;

    rft_cfg #(.LUT_AW(LUT_AW), .SYM_W(SYM_W), .FRM_W(FRM_W), .DEF_FTC(DEF_FTC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .rd_idx(ptr), .act_len(act_len), .act_last(act_last),
        .act_ftc(act_ftc), .arm_req(arm_req), .pending(commit_pending)
    );

    rft_frame_ctr #(.FRM_W(FRM_W), .FNUM_W(FNUM_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .act_ftc(act_ftc),
        .running(running), .smp(sample_cnt), .fnum(frame_num),
        .frame_last(frame_last), .commit(commit), .frame_start(frame_start)
    );

    rft_sym_walk #(.LUT_AW(LUT_AW), .SYM_W(SYM_W)) u_sym (
        .clk(clk), .rst_n(rst_n), .run(running), .chk(frame_last), .commit(commit),
        .arm(arm_req), .len_tc(act_len), .last(act_last), .ptr(ptr),
        .sym_start(sym_start), .err(err_flag)
    );

    assign sym_idx = ptr;
    assign halted  = !running;
endmodule

// File: tb/sim_rft_frame_timer.sv
module sim_rft_frame_timer;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        frame_start, sym_start, err_flag, halted, commit_pending;
    logic [23:0] sample_cnt;
    logic [7:0]  sym_idx;
    logic [11:0] frame_num;

    int checks = 0, fails = 0;
    int cyc = 0, last_fs = 0, last_len = 0, last_syms = 0, sym_acc = 0;

    rft_frame_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .sym_start(sym_start),
        .sample_cnt(sample_cnt), .sym_idx(sym_idx), .frame_num(frame_num),
        .err_flag(err_flag), .halted(halted), .commit_pending(commit_pending)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Measures frame spacing and symbol starts per frame.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && frame_start) begin
            last_len  = cyc - last_fs;
            last_fs   = cyc;
            last_syms = sym_acc;
            sym_acc   = sym_start ? 1 : 0;
        end else if (sym_start) begin
            sym_acc++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[8:0]; wr_data = d[23:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start);
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic nominal();
        for (int j = 0; j < 4; j++) wr(j, 4);
        wr(9'h100, 3);
        wr(9'h101, 19);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        chk(halted && !frame_start && !sym_start && !err_flag && !commit_pending
            && frame_num == 0 && sample_cnt == 0, "R1 reset in", int'(halted), 1);
        rst_n = 1'b1;
        step(1);
        chk(halted && !frame_start && !err_flag && !commit_pending, "R1 after reset",
            int'(halted), 1);

        // Nominal 20-sample frame of four 5-sample symbols.
        nominal();
        chk(commit_pending, "R7 pending after write", int'(commit_pending), 1);
        enable = 1'b1;
        step(1);
        chk(frame_start && sym_start && sym_idx == 0, "R10 start from halted",
            int'(frame_start), 1);
        chk(frame_num == 0, "R11 first frame number", int'(frame_num), 0);
        chk(!commit_pending, "R7 pending cleared", int'(commit_pending), 0);
        wait_fs();
        chk(last_len == 20, "R2 frame spacing", last_len, 20);
        chk(last_syms == 4, "R3 symbols per frame", last_syms, 4);

        // Looping table {3,7}; writes made mid-frame must not touch this frame.
        wr(0, 2); wr(1, 6); wr(9'h100, 1);
        wait_fs();
        chk(last_len == 20 && last_syms == 4, "R5 no mid-frame effect", last_syms, 4);
        step(3);
        chk(sym_start && sym_idx == 1 && sample_cnt == 3, "R3 symbol length", int'(sym_idx), 1);
        step(7);
        chk(sym_start && sym_idx == 0 && sample_cnt == 10, "R4 loop to entry 0",
            int'(sample_cnt), 10);
        wait_fs();
        chk(last_len == 20 && last_syms == 4, "R4 looped frame", last_syms, 4);
        wr(9'h101, 22);
        wait_fs(); wait_fs();
        chk(last_len == 23 && last_syms == 5 && !err_flag, "R4 partial pass", last_syms, 5);

        // Per-frame +/-1 nudges, moving the adjusted symbol across the table.
        nominal();
        wait_fs(); wait_fs();
        for (int k = 0; k < 12; k++) begin
            int d;
            d = (k % 3 == 0) ? 0 : ((k % 3 == 1) ? 1 : -1);
            for (int j = 0; j < 4; j++) wr(j, (j == k % 4) ? 4 + d : 4);
            wr(9'h101, 19 + d);
            wait_fs();
            chk(!commit_pending, "R7 landed in time", int'(commit_pending), 0);
            wait_fs();
            chk(last_len == 20 + d && last_syms == 4 && !err_flag, "R6 nudged frame",
                last_len, 20 + d);
        end

        // Mismatch: frame one sample longer than the table sum.
        nominal();
        wait_fs(); wait_fs();
        wr(9'h101, 20);
        wait_fs();
        chk(!err_flag, "R8 no error before bad frame ends", int'(err_flag), 0);
        wait_fs();
        chk(err_flag, "R8 error raised", int'(err_flag), 1);
        wait_fs();
        chk(last_syms == 0 && last_len == 21, "R8 symbols stopped", last_syms, 0);
        wr(9'h101, 19); wr(9'h102, 0);
        step(2);
        chk(err_flag, "R9 error held until boundary", int'(err_flag), 1);
        wait_fs();
        chk(!err_flag && sym_start && sym_idx == 0, "R9 re-armed", int'(err_flag), 0);
        wait_fs();
        chk(last_syms == 4 && last_len == 20, "R9 symbols resume", last_syms, 4);

        // Halt at frame end, then a full 140-entry table.
        enable = 1'b0;
        step(19);
        chk(!halted && sample_cnt == 19, "R10 frame finishes", int'(halted), 0);
        step(1);
        chk(halted && !frame_start, "R10 halted after frame", int'(halted), 1);
        for (int i = 0; i < 140; i++) wr(i, 1);
        wr(9'h100, 139); wr(9'h101, 279);
        enable = 1'b1;
        step(1);
        chk(frame_start && frame_num == 0, "R11 restart frame number", int'(frame_num), 0);
        wait_fs();
        chk(last_len == 280 && last_syms == 140 && !err_flag, "R4 full table",
            last_syms, 140);

        // Frame-number wrap with 2-sample frames.
        enable = 1'b0;
        while (!halted) step(1);
        wr(0, 1); wr(9'h100, 0); wr(9'h101, 1);
        enable = 1'b1;
        step(1);
        chk(frame_start && frame_num == 0, "R11 wrap run start", int'(frame_num), 0);
        for (int i = 1; i <= 4096; i++) begin
            wait_fs();
            if (i == 4095) chk(frame_num == 4095, "R11 top count", int'(frame_num), 4095);
            if (i == 4096) chk(frame_num == 0 && last_len == 2, "R11 wrap", int'(frame_num), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule